// File: doc/BRIEF.md
# Banked CMOS Real-Time-Clock Register File

This block is the register side of a battery-backed real-time clock. Software reaches it through a pair of ports. A write to the index port selects a register and also latches a flag that disables the non-maskable interrupt. Writes and reads on the data port then reach that register. Most indexes are plain storage bytes. A few indexes are special:

- Indexes 0x00, 0x02 and 0x04 return the seconds, minutes and hours of a running clock. The clock advances on a one-second tick input.
- Indexes 0x0A, 0x0B and 0x0D are status registers, and each masks what is written to it.

The block can be built in two sizes. The small build masks every index to six bits. The large build masks indexes to seven bits and adds a bank bit. A separate chipset index/data port pair sets and clears the bank bit. When the bank bit is set, indexes of 64 and above are moved up by 64, and the seven-bit mask is then applied again.

Status register B selects whether time values are read as packed BCD or as binary. Status register A reports an update-in-progress flag for a short window after every tick. Its low four bits, together with bit 6 of B, are also driven out to the periodic-rate logic elsewhere in the chip.

Top module: `cmos_rtc_regfile`

## Requirements
- R1: A write on the index port latches `wdata` ANDed with the address mask as the current index. The mask is 0x7F in the large build and 0x3F in the small build. Bit 7 of the same write is latched separately on `nmi_off`.
- R2: In the large build, a data access whose latched index is 64 or more while the bank bit is set uses the address (index + 64) AND 0x7F. Other accesses use the latched index unchanged.
- R3: A chipset data write while the chipset index is 0x1D sets the bank bit to bit 5 of `wdata`. `chip_rdata` is 0x20 or 0x00 at chipset index 0x1D, following the bank bit, and is 0x00 at any other chipset index.
- R4: A data write to index 0x0A stores only bits 6:0. `rate_sel` always equals bits 3:0 of the stored value.
- R5: A data write to index 0x0B stores only bits 6:0. `bcd_mode` is the inverse of stored bit 2, and `periodic_en` equals stored bit 6.
- R6: A data write to index 0x0D keeps only bit 7. Bits 6:0 of that register always read as zero.
- R7: After reset the following hold:
  - register 0x0A reads 0x26, 0x0B reads 0x02 and 0x0D reads 0x80;
  - the index, the NMI flag, the bank bit and the clock are zero;
  - every other storage byte reads 0x00.
- R8: Each cycle with `sec_tick` high advances the clock by one second. Seconds and minutes wrap at 59 and hours wrap at 23. Reads of 0x00, 0x02 and 0x04 return the clock, and data writes to these indexes do not change what is read there.
- R9: When `bcd_mode` is high, a clock value v is read as ((v/10)<<4)|(v%10). Otherwise it is read as the plain binary value.
- R10: Bit 7 of a read of 0x0A is 1 for UIP_CYCLES cycles after each tick and 0 at all other times.
- R11: A data write to any other index stores the full byte, and a read there returns it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| chip_idx_wr | input | 1 | Chipset index write strobe |
| chip_data_wr | input | 1 | Chipset data write strobe |
| wdata | input | 8 | Write data shared by all four strobes |
| sec_tick | input | 1 | One-second tick, one second per high cycle |
| rdata | output | 8 | Data-port read value at the effective index |
| chip_rdata | output | 8 | Chipset data read value |
| nmi_off | output | 1 | Latched NMI-disable flag |
| rate_sel | output | 4 | Periodic-rate divider select |
| periodic_en | output | 1 | Periodic timer enable |
| bcd_mode | output | 1 | High when clock reads are BCD |

## Verification
The hardest state to reach from the ports is the hours counter wrapping from 23:59:59 back to midnight, because only a whole day of ticks leads there. The bench holds `sec_tick` high for long unbroken runs, so that each cycle counts as one second. This moves the clock through a full day in about 86,400 cycles, with reads taken at the minute and day boundaries.

The bank remap is checked across two index aliases. The bench writes through a high index with the bank bit set, and then reads back through the low alias with the bank bit clear.

// File: rtl/cmos_rtc_pkg.sv
// Package: index constants and the BCD formatting helper shared by the
// register file. Assumes clock values never exceed 99.
package cmos_rtc_pkg;

    localparam logic [7:0] IX_SEC       = 8'h00;
    localparam logic [7:0] IX_MIN       = 8'h02;
    localparam logic [7:0] IX_HOUR      = 8'h04;
    localparam logic [7:0] IX_STAT_A    = 8'h0A;
    localparam logic [7:0] IX_STAT_B    = 8'h0B;
    localparam logic [7:0] IX_STAT_D    = 8'h0D;
    localparam logic [7:0] CHIP_BANK_IX = 8'h1D;

    localparam logic [7:0] RST_STAT_A = 8'h26;
    localparam logic [7:0] RST_STAT_B = 8'h02;
    localparam logic [7:0] RST_STAT_D = 8'h80;

    // Packs a binary value below 100 into two BCD digits.
    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/cmos_index_unit.sv
// Index unit: holds the index latch with its NMI-disable flag, the chipset
// index and bank bit, and computes the effective storage address.
// Assumes the strobes are single-cycle and never asserted together.
module cmos_index_unit #(
    parameter logic [7:0] ADDR_MASK = 8'h7F,
    parameter bit         HAS_BANK  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       chip_idx_wr,
    input  logic       chip_data_wr,
    input  logic [7:0] wdata,
    output logic [7:0] eff_idx,
    output logic       nmi_off,
    output logic [7:0] chip_rdata
);
    import cmos_rtc_pkg::*;

    logic [7:0] idx_q;
    logic [7:0] chip_idx_q;
    logic       bank_q;

    // Latch the masked index and the NMI-disable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            nmi_off <= 1'b0;
        end else if (idx_wr) begin
            idx_q   <= wdata & ADDR_MASK;
            nmi_off <= wdata[7];
        end
    end

    // Latch the chipset index and update the bank bit at its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_idx_q <= 8'h00;
            bank_q     <= 1'b0;
        end else begin
            if (chip_idx_wr)
                chip_idx_q <= wdata;
            if (chip_data_wr && chip_idx_q == CHIP_BANK_IX && HAS_BANK)
                bank_q <= wdata[5];
        end
    end

    // Chipset read value: the bank bit in bit 5 at its index, else zero.
    always_comb begin
        chip_rdata = 8'h00;
        if (chip_idx_q == CHIP_BANK_IX)
            chip_rdata = {2'b00, bank_q, 5'b00000};
    end

    // Effective address: shift the upper range when banked, then mask again.
    always_comb begin
        if (bank_q && idx_q >= 8'd64)
            eff_idx = (idx_q + 8'd64) & ADDR_MASK;
        else
            eff_idx = idx_q;
    end
endmodule

// File: rtl/cmos_time_unit.sv
// Time unit: binary seconds/minutes/hours advanced once per high cycle of
// sec_tick, plus a down-counter that marks the update window.
// Assumes UIP_CYCLES fits in eight bits.
module cmos_time_unit #(
    parameter int UIP_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    output logic [7:0] sec_bin,
    output logic [7:0] min_bin,
    output logic [7:0] hour_bin,
    output logic       uip
);
    localparam logic [7:0] UIP_LOAD = 8'(UIP_CYCLES);

    logic [7:0] uip_cnt;

    // Advance the clock with carries at 59 seconds, 59 minutes and 23 hours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_bin  <= 8'd0;
            min_bin  <= 8'd0;
            hour_bin <= 8'd0;
        end else if (sec_tick) begin
            if (sec_bin == 8'd59) begin
                sec_bin <= 8'd0;
                if (min_bin == 8'd59) begin
                    min_bin  <= 8'd0;
                    hour_bin <= (hour_bin == 8'd23) ? 8'd0 : hour_bin + 8'd1;
                end else begin
                    min_bin <= min_bin + 8'd1;
                end
            end else begin
                sec_bin <= sec_bin + 8'd1;
            end
        end
    end

    // Reload the update window on a tick and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uip_cnt <= 8'd0;
        else if (sec_tick)
            uip_cnt <= UIP_LOAD;
        else if (uip_cnt != 8'd0)
            uip_cnt <= uip_cnt - 8'd1;
    end

    assign uip = (uip_cnt != 8'd0);
endmodule

// File: rtl/cmos_reg_store.sv
// Register store: byte array with per-index write masks for the status
// registers and their reset defaults. Assumes addr is below DEPTH.
module cmos_reg_store #(
    parameter int DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte,
    output logic [7:0] stat_a,
    output logic [7:0] stat_b
);
    import cmos_rtc_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];
    logic [7:0] masked;

    // Apply the write mask of the addressed status register.
    always_comb begin
        case (addr)
            IX_STAT_A: masked = wdata & 8'h7F;
            IX_STAT_B: masked = wdata & 8'h7F;
            IX_STAT_D: masked = wdata & 8'h80;
            default:   masked = wdata;
        endcase
    end

    // Load reset defaults, otherwise store the masked byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(IX_STAT_A))
                    mem[i] <= RST_STAT_A;
                else if (i == int'(IX_STAT_B))
                    mem[i] <= RST_STAT_B;
                else if (i == int'(IX_STAT_D))
                    mem[i] <= RST_STAT_D;
                else
                    mem[i] <= 8'h00;
            end
        end else if (wr_en) begin
            mem[addr[AW-1:0]] <= masked;
        end
    end

    assign rd_byte = mem[addr[AW-1:0]];
    assign stat_a  = mem[IX_STAT_A[AW-1:0]];
    assign stat_b  = mem[IX_STAT_B[AW-1:0]];
endmodule

// File: rtl/cmos_rtc_regfile.sv
// Top: banked RTC register file. It joins the index unit, the time unit
// and the register store, and formats clock reads in BCD or binary.
// Assumes the port strobes are single-cycle.
module cmos_rtc_regfile #(
    parameter bit LARGE      = 1'b1,
    parameter int UIP_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic       chip_idx_wr,
    input  logic       chip_data_wr,
    input  logic [7:0] wdata,
    input  logic       sec_tick,
    output logic [7:0] rdata,
    output logic [7:0] chip_rdata,
    output logic       nmi_off,
    output logic [3:0] rate_sel,
    output logic       periodic_en,
    output logic       bcd_mode
);
    import cmos_rtc_pkg::*;

    localparam logic [7:0] ADDR_MASK = LARGE ? 8'h7F : 8'h3F;
    localparam int         DEPTH     = int'(ADDR_MASK) + 1;

    logic [7:0] eff_idx;
    logic [7:0] sec_bin, min_bin, hour_bin;
    logic       uip;
    logic [7:0] rd_byte, stat_a, stat_b;

    cmos_index_unit #(.ADDR_MASK(ADDR_MASK), .HAS_BANK(LARGE)) i_index (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .chip_idx_wr(chip_idx_wr),
        .chip_data_wr(chip_data_wr), .wdata(wdata), .eff_idx(eff_idx),
        .nmi_off(nmi_off), .chip_rdata(chip_rdata)
    );

    cmos_time_unit #(.UIP_CYCLES(UIP_CYCLES)) i_time (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sec_bin(sec_bin),
        .min_bin(min_bin), .hour_bin(hour_bin), .uip(uip)
    );

    cmos_reg_store #(.DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .addr(eff_idx),
        .wdata(wdata), .rd_byte(rd_byte), .stat_a(stat_a), .stat_b(stat_b)
    );

    assign rate_sel    = stat_a[3:0];
    assign periodic_en = stat_b[6];
    assign bcd_mode    = ~stat_b[2];

    // Select the read source and format clock values.
    always_comb begin
        case (eff_idx)
            IX_SEC:    rdata = bcd_mode ? bin_to_bcd(sec_bin)  : sec_bin;
            IX_MIN:    rdata = bcd_mode ? bin_to_bcd(min_bin)  : min_bin;
            IX_HOUR:   rdata = bcd_mode ? bin_to_bcd(hour_bin) : hour_bin;
            IX_STAT_A: rdata = {uip, rd_byte[6:0]};
            default:   rdata = rd_byte;
        endcase
    end
endmodule

// File: rtl/cmos_rtc_checker.sv
// Checker: temporal properties of the register file, attached by bind.
module cmos_rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_wr,
    input logic       data_wr,
    input logic [7:0] wdata,
    input logic       sec_tick,
    input logic       nmi_off,
    input logic [7:0] eff_idx,
    input logic [3:0] rate_sel,
    input logic       bcd_mode,
    input logic       periodic_en,
    input logic [7:0] chip_rdata,
    input logic       uip,
    input logic [7:0] sec_bin
);
    AST_NMI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> nmi_off == $past(wdata[7]));                            // R1
    AST_BANK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rdata & 8'hDF) == 8'h00);                                    // R3
    AST_RATE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && eff_idx == 8'h0A) |=> rate_sel == $past(wdata[3:0]));  // R4
    AST_B_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && eff_idx == 8'h0B) |=>
            (bcd_mode == !$past(wdata[2]) && periodic_en == $past(wdata[6]))); // R5
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bin < 8'd60);                                                  // R8
    AST_UIP_START: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> uip);                                                 // R10
endmodule

bind cmos_rtc_regfile cmos_rtc_checker i_cmos_rtc_checker (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(wdata), .sec_tick(sec_tick), .nmi_off(nmi_off), .eff_idx(eff_idx),
    .rate_sel(rate_sel), .bcd_mode(bcd_mode), .periodic_en(periodic_en),
    .chip_rdata(chip_rdata), .uip(uip), .sec_bin(sec_bin)
);

// File: tb/test_cmos_rtc_regfile.sv
// Directed bench: one task per scenario, each checking its own results.
module test_cmos_rtc_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int UIP_CYC    = 4;
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, data_wr = 1'b0;
    logic       chip_idx_wr = 1'b0, chip_data_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       sec_tick = 1'b0;
    logic [7:0] rdata, chip_rdata;
    logic       nmi_off, periodic_en, bcd_mode;
    logic [3:0] rate_sel;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmos_rtc_regfile #(.LARGE(1'b1), .UIP_CYCLES(UIP_CYC)) i_cmos_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
        .chip_idx_wr(chip_idx_wr), .chip_data_wr(chip_data_wr), .wdata(wdata),
        .sec_tick(sec_tick), .rdata(rdata), .chip_rdata(chip_rdata),
        .nmi_off(nmi_off), .rate_sel(rate_sel), .periodic_en(periodic_en),
        .bcd_mode(bcd_mode)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic set_bank(input logic on);
        @(negedge clk); chip_idx_wr = 1'b1; wdata = 8'h1D;
        @(negedge clk); chip_idx_wr = 1'b0; chip_data_wr = 1'b1; wdata = on ? 8'h20 : 8'h00;
        @(negedge clk); chip_data_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset;
        chk(rdata, 8'h00, "R7 index 0 clock after reset");
        chk({7'd0, nmi_off}, 8'h00, "R7 nmi flag");
        chk(chip_rdata, 8'h00, "R7 chip read");
        chk({4'd0, rate_sel}, 8'h06, "R7 rate_sel");
        chk({6'd0, bcd_mode, periodic_en}, 8'h02, "R7 bcd/periodic");
        set_idx(8'h0A); chk(rdata, 8'h26, "R7 status A");
        set_idx(8'h0B); chk(rdata, 8'h02, "R7 status B");
        set_idx(8'h0D); chk(rdata, 8'h80, "R7 status D");
        set_idx(8'h20); chk(rdata, 8'h00, "R7 storage zero");
    endtask

    task automatic t_index_storage;
        set_idx(8'h8E);
        chk({7'd0, nmi_off}, 8'h01, "R1 nmi set");
        wr_data(8'h3C); chk(rdata, 8'h3C, "R11 full byte at 0x0E");
        set_idx(8'h0E);
        chk({7'd0, nmi_off}, 8'h00, "R1 nmi clear");
        chk(rdata, 8'h3C, "R1 index masked 0x8E->0x0E");
        set_idx(8'h30); wr_data(8'hFF); chk(rdata, 8'hFF, "R11 byte 0xFF");
        set_idx(8'hFF); wr_data(8'h77);
        set_idx(8'h7F); chk(rdata, 8'h77, "R1 mask 0xFF->0x7F");
    endtask

    task automatic t_status;
        set_idx(8'h0A); wr_data(8'hFF);
        chk(rdata, 8'h7F, "R4 status A low 7 bits");
        chk({4'd0, rate_sel}, 8'h0F, "R4 rate_sel");
        wr_data(8'h23); chk({4'd0, rate_sel}, 8'h03, "R4 rate_sel 3");
        set_idx(8'h0B); wr_data(8'hC4);
        chk(rdata, 8'h44, "R5 status B low 7 bits");
        chk({6'd0, bcd_mode, periodic_en}, 8'h01, "R5 binary + periodic");
        wr_data(8'h02);
        chk({6'd0, bcd_mode, periodic_en}, 8'h02, "R5 bcd, no periodic");
        set_idx(8'h0D); wr_data(8'h7F); chk(rdata, 8'h00, "R6 D low bits dropped");
        wr_data(8'hFF); chk(rdata, 8'h80, "R6 D bit 7 kept");
    endtask

    task automatic t_bank;
        set_bank(1'b1); chk(chip_rdata, 8'h20, "R3 bank read set");
        set_idx(8'h45); wr_data(8'hA5); chk(rdata, 8'hA5, "R2 banked write");
        set_bank(1'b0); chk(chip_rdata, 8'h00, "R3 bank read clear");
        chk(rdata, 8'h00, "R2 unbanked 0x45 separate");
        set_idx(8'h05); chk(rdata, 8'hA5, "R2 alias (0x45+64)&0x7F=0x05");
        set_bank(1'b1); set_idx(8'h05); chk(rdata, 8'hA5, "R2 low index not shifted");
        set_bank(1'b0);
        @(negedge clk); chip_idx_wr = 1'b1; wdata = 8'h10;
        @(negedge clk); chip_idx_wr = 1'b0;
        chk(chip_rdata, 8'h00, "R3 other chip index");
    endtask

    task automatic t_time;
        set_idx(8'h00); wr_data(8'h33); chk(rdata, 8'h00, "R8 write to seconds ignored");
        ticks(59); chk(rdata, 8'h59, "R9 BCD 59 seconds");
        ticks(1);  chk(rdata, 8'h00, "R8 seconds wrap");
        set_idx(8'h02); chk(rdata, 8'h01, "R8 minute carry");
        set_idx(8'h0B); wr_data(8'h06);
        chk({7'd0, bcd_mode}, 8'h00, "R5 binary selected");
        ticks(86339);
        set_idx(8'h04); chk(rdata, 8'd23, "R9 binary hours 23");
        set_idx(8'h02); chk(rdata, 8'd59, "R9 binary minutes 59");
        wr_data(8'h11); chk(rdata, 8'd59, "R8 write to minutes ignored");
        ticks(1);
        chk(rdata, 8'h00, "R8 minutes wrap at day end");
        set_idx(8'h04); chk(rdata, 8'h00, "R8 hours wrap");
        set_idx(8'h0B); wr_data(8'h02);
        ticks(12); set_idx(8'h00); chk(rdata, 8'h12, "R9 BCD 12 seconds");
    endtask

    task automatic t_uip;
        set_idx(8'h0A);
        repeat (UIP_CYC + 1) @(negedge clk);
        chk(rdata & 8'h80, 8'h00, "R10 idle flag");
        ticks(1); chk(rdata & 8'h80, 8'h80, "R10 flag after tick");
        repeat (UIP_CYC - 1) @(negedge clk);
        chk(rdata & 8'h80, 8'h80, "R10 flag at window end");
        @(negedge clk); chk(rdata & 8'h80, 8'h00, "R10 flag cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_storage();
        t_status();
        t_bank();
        t_time();
        t_uip();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule